// File: doc/BRIEF.md
# Vector Mask Expansion Unit

This block turns a compact bit mask into a full 128-bit vector of uniform elements. It receives a 32-bit instruction word, a scalar source operand and an input strobe. It recognises six mask-move encodings and writes one registered 128-bit result. In that result every element of the selected size is either all ones or all zeros, decided by one mask bit. Five encodings take the mask bits from the scalar operand, with elements of 1, 2, 4, 8 or 16 bytes. The sixth builds a 16-bit byte mask from three separate immediate fields of the instruction word.

The result is presented one clock after the strobe, together with the destination register index and a valid flag. Reading and writing the register file, and any checks on feature enablement, happen outside this block. An instruction word that matches none of the six encodings produces no valid result.

Top module: `vmask_expand_unit`

## Requirements
- R1: A register-sourced form is recognised when insn[31:26] = 6'b000100, insn[10:0] = 11'b11001000010 and insn[20:16] is one of 5'b10000 (1-byte elements), 5'b10001 (2-byte), 5'b10010 (4-byte), 5'b10011 (8-byte) or 5'b10100 (16-byte).
- R2: The immediate form is recognised when insn[31:26] = 6'b000100 and insn[5:1] = 5'b01010. Its byte mask is {insn[15:6], insn[20:16], insn[0]}, with mask bit 15 leftmost. Mask bit b drives result byte b, so mask bits 15:8 fill the upper 64-bit half.
- R3: For a register form with elements of w bytes, result element e (e = 0 for the least significant element, e < 16/w) is all ones when src_op[e] is 1 and all zeros when it is 0. Operand bits at or above position 16/w have no effect.
- R4: The lower half of the used mask bits drives the elements of result bits 63:0, and the upper half drives the elements of result bits 127:64.
- R5: For the 16-byte element form, src_op[0] is copied into all 128 result bits.
- R6: The result, the target index and out_valid are updated on the rising edge that samples in_valid high with a recognised encoding. out_valid is high for exactly that one cycle per strobe.
- R7: When in_valid is low, or when the instruction matches none of the six encodings, out_valid is low on the next cycle and out_vec is all zeros.
- R8: While rst_n is low at a rising edge, out_valid and out_vec are cleared, whatever the other inputs are.
- R9: When out_valid is high, out_tgt equals insn[25:21] as sampled with the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction strobe |
| insn | input | 32 | Instruction word |
| src_op | input | 64 | Scalar source operand that supplies the mask bits |
| out_valid | output | 1 | Result valid, one cycle after a recognised strobe |
| out_tgt | output | 5 | Destination vector register index |
| out_vec | output | 128 | Expanded mask vector |

## Verification
The assertions assume that rst_n is low at the first rising edge. They also assume that in_valid, insn and the least significant operand bit carry known values at every edge after reset. The stimulus drives all inputs to defined values from time zero and changes them only on falling edges. Random instruction words are built from the valid encodings, from near misses of those encodings and from fully random words, so no X value ever reaches the decoder.

// File: rtl/vmx_pkg.sv
package vmx_pkg;

   localparam int unsigned INSN_W      = 32;
   localparam int unsigned REG_IDX_W   = 5;
   localparam int unsigned BYTE_MASK_W = 16;
   localparam int unsigned SIZE_SEL_W  = 3;
   localparam int unsigned NUM_REG_SIZES = 5;

   localparam logic [5:0]  PRIMARY_OP     = 6'b000100;
   localparam logic [10:0] REG_FORM_XO    = 11'b11001000010;
   localparam logic [4:0]  IMM_FORM_XO    = 5'b01010;
   localparam logic [4:0]  SIZE_CODE_BASE = 5'b10000;

   typedef enum logic [1:0] {
      FORM_NONE = 2'd0,
      FORM_REG  = 2'd1,
      FORM_IMM  = 2'd2
   } form_e;

   typedef struct packed {
      logic                   hit;
      form_e                  form;
      logic [SIZE_SEL_W-1:0]  size_log2;
      logic [REG_IDX_W-1:0]   tgt;
      logic [BYTE_MASK_W-1:0] mask;
   } dec_t;

endpackage

// File: rtl/vmx_decode.sv
module vmx_decode
   import vmx_pkg::*;
#(
   parameter int unsigned MASK_W = BYTE_MASK_W
)(
   input  logic [INSN_W-1:0] insn,
   input  logic [MASK_W-1:0] src_mask,
   output dec_t              dec
);

   localparam logic [4:0] SIZE_CODE_LAST = SIZE_CODE_BASE + 5'(NUM_REG_SIZES - 1);

   logic       opc_ok;
   logic       reg_ok;
   logic       imm_ok;
   logic [4:0] size_code;
   logic [4:0] size_off;

   always_comb begin
      size_code = insn[20:16];
      size_off  = size_code - SIZE_CODE_BASE;
      opc_ok    = (insn[31:26] == PRIMARY_OP);
      reg_ok    = opc_ok && (insn[10:0] == REG_FORM_XO)
                  && (size_code >= SIZE_CODE_BASE)
                  && (size_code <= SIZE_CODE_LAST);
      imm_ok    = opc_ok && (insn[5:1] == IMM_FORM_XO);
   end

   always_comb begin
      dec           = '0;
      dec.form      = FORM_NONE;
      dec.tgt       = insn[25:21];
      if (reg_ok) begin
         dec.hit       = 1'b1;
         dec.form      = FORM_REG;
         dec.size_log2 = size_off[SIZE_SEL_W-1:0];
         dec.mask      = src_mask;
      end else if (imm_ok) begin
         dec.hit       = 1'b1;
         dec.form      = FORM_IMM;
         dec.size_log2 = '0;
         dec.mask      = {insn[15:6], insn[20:16], insn[0]};
      end
   end

endmodule

// File: rtl/vmx_spread.sv
module vmx_spread
   import vmx_pkg::*;
#(
   parameter int unsigned VEC_BYTES = 16,
   parameter int unsigned MASK_W    = BYTE_MASK_W
)(
   input  logic [MASK_W-1:0]     mask,
   input  logic [SIZE_SEL_W-1:0] size_log2,
   output logic [VEC_BYTES*8-1:0] vec
);

   localparam int unsigned VEC_W     = VEC_BYTES * 8;
   localparam int unsigned NUM_SIZES = $clog2(VEC_BYTES) + 1;

   logic [VEC_W-1:0] by_size [NUM_SIZES];

   // One candidate vector per element size; element e always follows mask
   // bit e, which places the low half of the used bits in the low 64 bits.
   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int unsigned ELEMS = VEC_BYTES >> g;
      localparam int unsigned EBITS = 8 << g;
      for (genvar e = 0; e < ELEMS; e++) begin : g_elem
         assign by_size[g][e*EBITS +: EBITS] = {EBITS{mask[e]}};
      end
   end

   always_comb begin
      vec = '0;
      for (int g = 0; g < NUM_SIZES; g++) begin
         if (size_log2 == SIZE_SEL_W'(g)) vec = by_size[g];
      end
   end

endmodule

// File: rtl/vmx_out_stage.sv
module vmx_out_stage #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned TGT_W = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TGT_W-1:0] tgt_d,
   input  logic [VEC_W-1:0] vec_d,
   output logic             valid_q,
   output logic [TGT_W-1:0] tgt_q,
   output logic [VEC_W-1:0] vec_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tgt_q   <= '0;
         vec_q   <= '0;
      end else begin
         valid_q <= load;
         tgt_q   <= load ? tgt_d : '0;
         vec_q   <= load ? vec_d : '0;
      end
   end

endmodule

// File: rtl/vmask_expand_unit.sv
module vmask_expand_unit
   import vmx_pkg::*;
#(
   parameter int unsigned SRC_W     = 64,
   parameter int unsigned VEC_BYTES = 16
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [INSN_W-1:0]       insn,
   input  logic [SRC_W-1:0]        src_op,
   output logic                    out_valid,
   output logic [REG_IDX_W-1:0]    out_tgt,
   output logic [VEC_BYTES*8-1:0]  out_vec
);

   localparam int unsigned VEC_W = VEC_BYTES * 8;

   // Parameter checks at elaboration.
   if (VEC_BYTES != BYTE_MASK_W) begin : g_bad_vec
      $error("vmask_expand_unit: VEC_BYTES must equal the byte-mask width");
   end
   if (SRC_W < BYTE_MASK_W) begin : g_bad_src
      $error("vmask_expand_unit: SRC_W must cover all mask bits");
   end

   // Operand bits above the widest mask never reach the datapath.
   if (SRC_W > BYTE_MASK_W) begin : g_src_hi
      logic unused_src_hi;
      assign unused_src_hi = ^src_op[SRC_W-1:BYTE_MASK_W];
   end

   dec_t             dec;
   logic [VEC_W-1:0] spread_vec;
   logic             load;

   vmx_decode #(
      .MASK_W (BYTE_MASK_W)
   ) u_decode (
      .insn     (insn),
      .src_mask (src_op[BYTE_MASK_W-1:0]),
      .dec      (dec)
   );

   vmx_spread #(
      .VEC_BYTES (VEC_BYTES),
      .MASK_W    (BYTE_MASK_W)
   ) u_spread (
      .mask      (dec.mask),
      .size_log2 (dec.size_log2),
      .vec       (spread_vec)
   );

   assign load = in_valid && dec.hit;

   vmx_out_stage #(
      .VEC_W (VEC_W),
      .TGT_W (REG_IDX_W)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .tgt_d   (dec.tgt),
      .vec_d   (spread_vec),
      .valid_q (out_valid),
      .tgt_q   (out_tgt),
      .vec_q   (out_vec)
   );

endmodule

// File: rtl/vmx_expand_chk.sv
module vmx_expand_chk #(
   parameter int unsigned VEC_W = 128
)(
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [31:0]      insn,
   input logic             src_lsb,
   input logic             out_valid,
   input logic [4:0]       out_tgt,
   input logic [VEC_W-1:0] out_vec
);

   logic bytes_uniform;
   logic qword_enc;

   always_comb begin
      bytes_uniform = 1'b1;
      for (int b = 0; b < VEC_W/8; b++) begin
         if (out_vec[b*8 +: 8] != 8'h00 && out_vec[b*8 +: 8] != 8'hFF)
            bytes_uniform = 1'b0;
      end
      qword_enc = (insn[31:26] == 6'b000100) && (insn[10:0] == 11'b11001000010)
                  && (insn[20:16] == 5'b10100);
   end

   // R6
   valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));

   // R7
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_vec == '0));

   // R9
   tgt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_tgt == $past(insn[25:21])));

   // R3
   elem_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> bytes_uniform);

   // R5
   qword_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && qword_enc) |=> (out_valid && out_vec == {VEC_W{$past(src_lsb)}}));

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_vec == '0));

endmodule

bind vmask_expand_unit vmx_expand_chk #(.VEC_W(VEC_BYTES*8)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .insn      (insn),
   .src_lsb   (src_op[0]),
   .out_valid (out_valid),
   .out_tgt   (out_tgt),
   .out_vec   (out_vec)
);

// File: tb/vmask_expand_unit_tb_top.sv
`timescale 1ns/1ps
module vmask_expand_unit_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  insn = '0;
   logic [63:0]  src_op = '0;
   logic         out_valid;
   logic [4:0]   out_tgt;
   logic [127:0] out_vec;

   int    checks = 0;
   int    failures = 0;
   bit    started = 0;
   bit    finished = 0;
   string cur_tag = "R8";

   bit           exp_valid;
   logic [4:0]   exp_tgt;
   logic [127:0] exp_vec;
   string        exp_tag;

   always #4 clk = ~clk;

   vmask_expand_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .insn      (insn),
      .src_op    (src_op),
      .out_valid (out_valid),
      .out_tgt   (out_tgt),
      .out_vec   (out_vec)
   );

   function automatic logic [31:0] reg_form(input logic [4:0] code, input logic [4:0] vrt,
                                            input logic [4:0] vrb);
      return {6'b000100, vrt, code, vrb, 11'b11001000010};
   endfunction

   function automatic logic [31:0] imm_form(input logic [4:0] vrt, input logic [15:0] m);
      return {6'b000100, vrt, m[5:1], m[15:6], 5'b01010, m[0]};
   endfunction

   // Behavioural expectation from the requirements.
   function automatic void predict(input logic [31:0] i, input logic [63:0] s,
                                   output bit hit, output logic [127:0] v);
      int unsigned sz;
      logic [15:0] m;
      hit = 0; v = '0; sz = 0; m = '0;
      if (i[31:26] == 6'd4 && i[10:0] == 11'b11001000010 &&
          i[20:16] >= 5'd16 && i[20:16] <= 5'd20) begin
         hit = 1; sz = 1 << (i[20:16] - 16); m = s[15:0];
      end else if (i[31:26] == 6'd4 && i[5:1] == 5'd10) begin
         hit = 1; sz = 1; m = {i[15:6], i[20:16], i[0]};
      end
      if (hit)
         for (int b = 0; b < 16; b++) v[b*8 +: 8] = m[b / sz] ? 8'hFF : 8'h00;
   endfunction

   always @(posedge clk) begin
      bit           h;
      logic [127:0] v;
      started = 1;
      exp_tag = cur_tag;
      if (!rst_n) begin
         exp_valid = 0; exp_tgt = '0; exp_vec = '0; exp_tag = "R8";
      end else begin
         predict(insn, src_op, h, v);
         exp_valid = in_valid && h;
         exp_tgt   = insn[25:21];
         exp_vec   = exp_valid ? v : '0;
      end
   end

   always @(negedge clk) begin
      if (started && !finished) begin
         checks++;
         if (out_valid !== exp_valid || out_vec !== exp_vec ||
             (exp_valid && out_tgt !== exp_tgt)) begin
            failures++;
            $display("FAIL %s: got v=%b tgt=%0d vec=%h exp v=%b tgt=%0d vec=%h",
                     exp_tag, out_valid, out_tgt, out_vec, exp_valid, exp_tgt, exp_vec);
         end
      end
   end

   task automatic apply(input logic [31:0] i, input logic [63:0] s, input bit v,
                        input string tag);
      @(negedge clk);
      insn = i; src_op = s; in_valid = v; cur_tag = tag;
   endtask

   initial begin
      // R8: strobe held during reset must not produce a result
      insn = reg_form(5'b10000, 5'd3, 5'd1); src_op = 64'hFFFF; in_valid = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      apply(reg_form(5'b10000, 5'd1, 5'd2), 64'h0000_0000_0000_A5C3, 1, "R1");
      apply(reg_form(5'b10001, 5'd2, 5'd2), 64'h0000_0000_0000_00B4, 1, "R1");
      apply(reg_form(5'b10010, 5'd3, 5'd2), 64'h0000_0000_0000_0009, 1, "R1");
      apply(reg_form(5'b10011, 5'd4, 5'd2), 64'h0000_0000_0000_0002, 1, "R1");
      apply(reg_form(5'b10100, 5'd5, 5'd2), 64'h0000_0000_0000_0001, 1, "R5");
      apply(reg_form(5'b10100, 5'd6, 5'd2), 64'hFFFF_FFFF_FFFF_FFFE, 1, "R5");
      apply(reg_form(5'b10000, 5'd7, 5'd2), 64'hFFFF_FFFF_FFFF_0000, 1, "R3");
      apply(reg_form(5'b10010, 5'd8, 5'd2), 64'h0000_0000_0000_FFF0, 1, "R3");
      apply(reg_form(5'b10011, 5'd9, 5'd2), 64'h0000_0000_0000_FFFC, 1, "R3");
      apply(reg_form(5'b10001, 5'd10, 5'd2), 64'h0000_0000_0000_000F, 1, "R4");
      apply(reg_form(5'b10001, 5'd11, 5'd2), 64'h0000_0000_0000_00F0, 1, "R4");
      apply(reg_form(5'b10000, 5'd12, 5'd2), 64'h0000_0000_0000_0080, 1, "R4");
      apply(imm_form(5'd13, 16'h8001), 64'hFFFF, 1, "R2");
      apply(imm_form(5'd14, 16'h00FF), 64'h0, 1, "R2");
      apply(imm_form(5'd15, 16'hFF00), 64'h0, 1, "R2");
      apply(imm_form(5'd16, 16'h0040), 64'h0, 1, "R2");
      apply(imm_form(5'd17, 16'h0020), 64'h0, 1, "R2");
      apply(imm_form(5'd18, 16'h0002), 64'h0, 1, "R2");
      apply(reg_form(5'b10101, 5'd19, 5'd2), 64'hFFFF, 1, "R7");
      apply(reg_form(5'b00000, 5'd20, 5'd2), 64'hFFFF, 1, "R7");
      apply(reg_form(5'b10000, 5'd21, 5'd2) ^ 32'h8000_0000, 64'hFFFF, 1, "R7");
      apply(reg_form(5'b10000, 5'd22, 5'd2) ^ 32'h0000_0400, 64'hFFFF, 1, "R7");
      apply(reg_form(5'b10000, 5'd23, 5'd2), 64'hFFFF, 0, "R7");
      apply(reg_form(5'b10000, 5'd31, 5'd2), 64'h5555, 1, "R9");
      apply(imm_form(5'd0, 16'hFFFF), 64'h0, 1, "R9");
      apply(reg_form(5'b10000, 5'd24, 5'd2), 64'h3C3C, 1, "R6");
      apply(reg_form(5'b10000, 5'd24, 5'd2), 64'h3C3C, 0, "R6");
      for (int n = 0; n < 600; n++) begin
         int unsigned pick;
         logic [31:0] w;
         pick = $urandom_range(0, 5);
         case (pick)
            0, 1: w = reg_form(5'(16 + $urandom_range(0, 4)), 5'($urandom), 5'($urandom));
            2:    w = imm_form(5'($urandom), 16'($urandom));
            3:    w = reg_form(5'($urandom), 5'($urandom), 5'($urandom));
            4:    w = reg_form(5'(16 + $urandom_range(0, 4)), 5'($urandom), 5'($urandom))
                      ^ (32'h1 << $urandom_range(0, 31));
            default: w = $urandom;
         endcase
         apply(w, {$urandom, $urandom}, 1'($urandom_range(0, 3) != 0), "R3");
      end
      // R8: reset in mid-stream clears a pending result
      apply(reg_form(5'b10000, 5'd1, 5'd2), 64'hFFFF, 1, "R8");
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; in_valid = 1'b0;
      repeat (3) @(negedge clk);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!finished) begin
         finished = 1;
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule